// File: doc/BRIEF.md
# Relocatable Peripheral Select Decoder

This block turns each bus cycle's 20-bit address into one of six active-low peripheral selects. All six sit inside a single relocatable block, aligned to 2 Kbyte, and each select owns one 256-byte window of it. The window index is address bits 10:8. Index 4 is a hole with no output, and index 7 falls outside the block. The block can decode either memory cycles over the 1-Mbyte space or I/O cycles over the 64-Kbyte space. For each cycle that matches, it drives the select in the address-phase clock and raises a bus-wait signal for the programmed number of clocks. It can also hold the cycle until an external ready input goes high.

Two configuration words arrive on a write-enable port. The base word holds the block base, plus the wait count and ready mode of selects 0–3. The auxiliary word holds the space choice, the pin mode of selects 5–6, and the wait count and ready mode of selects 5–6. In the other pin mode, selects 5 and 6 become address outputs that carry the current cycle's address bits 1 and 2.

Top module: `pcs_decoder`

## Requirements
- R1: After reset, with nothing written, every `sel_n` bit is 1 and `bus_wait` is 0.
- R2: The base word written with `cfg_sel`=0 places the block base in bits 15:7, and these are compared with address bits 19:11. A matching cycle whose bits 10:8 equal k, for k in 0–3, 5 or 6, drives `sel_n[k]` low. Bit 6 of the base word has no effect on decoding.
- R3: `sel_n[4]` never goes low. A cycle with bits 10:8 equal to 4 or 7, or with an address outside the block, drives no select low and leaves `bus_wait` at 0.
- R4: No select goes low until both words have been written since reset.
- R5: Base-word bits 3:0 give a wait count W from 0 to 15 for selects 0–3. `bus_wait` is high for exactly W clocks, starting in the address-phase clock.
- R6: Auxiliary-word bits 1:0 give a wait count from 0 to 3 for selects 5–6, with the same timing as R5.
- R7: A set ready bit (base-word bit 4 for selects 0–3, auxiliary-word bit 2 for selects 5–6) keeps `bus_wait` high after the count while `bus_ready` is 0. With the bit clear, `bus_ready` is ignored.
- R8: Auxiliary-word bit 3 set makes the block decode only I/O cycles (`bus_is_io`=1), comparing address bits 15:11 with base-word bits 11:7. Clear, it decodes only memory cycles, using the full comparison of R2.
- R9: Auxiliary-word bit 4 set makes `sel_n[5]` and `sel_n[6]` follow `bus_addr[1]` and `bus_addr[2]` at all times. Only the auxiliary word needs to be written for this. In this mode, windows 5 and 6 decode to nothing.
- R10: In a matching cycle, the select goes low in the same clock as `cyc_start` and stays low through the last clock of the cycle, which is the first clock with `bus_wait` low. At most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = base word, 1 = auxiliary word |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | Address-phase strobe, one clock, issued only between cycles |
| bus_addr | input | 20 | Cycle address, held for the whole cycle |
| bus_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_ready | input | 1 | External ready, used in ready mode |
| sel_n | output | 7 | Active-low selects, indexed by window; bit 4 is always 1 |
| bus_wait | output | 1 | Wait request to the bus master |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 16-bit I/O space, 256-byte windows, and 4-bit and 2-bit wait fields. With these sizes it can sweep every window index against several offsets inside a window, every wait value of both groups, and all four address-pin codes. Expected selects, wait lengths and pin levels come from an arithmetic model of the two configuration words. Several bases, a sweep of ready delays, and both space settings are crossed with these sweeps.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   // configuration word choice
   typedef enum logic {
      CFG_BASE = 1'b0,
      CFG_AUX  = 1'b1
   } cfg_sel_e;

   // window index inside the block
   localparam int SLOT_W    = 3;
   localparam int SLOTS     = 1 << SLOT_W;
   localparam int HOLE_SLOT = 4;
   localparam int NSEL      = SLOTS - 1;
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
   import pcs_pkg::*;
#(
   parameter int CFG_W  = 16,
   parameter int BASE_W = 9,
   parameter int WA_W   = 4,
   parameter int WB_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [CFG_W-1:0]  wdata,
   output logic [BASE_W-1:0] base_o,
   output logic [WA_W-1:0]   wait_a_o,
   output logic              rdy_a_o,
   output logic [WB_W-1:0]   wait_b_o,
   output logic              rdy_b_o,
   output logic              io_o,
   output logic              amode_o,
   output logic              base_seen_o,
   output logic              aux_seen_o
);
   localparam int BASE_LSB  = CFG_W - BASE_W;
   localparam int RDY_A_BIT = WA_W;
   localparam int RDY_B_BIT = WB_W;
   localparam int IO_BIT    = WB_W + 1;
   localparam int AMODE_BIT = WB_W + 2;

   generate
      if (RDY_A_BIT + 1 >= BASE_LSB) begin : g_bad_base
         $error("base field overlaps the group-A fields");
      end
      if (AMODE_BIT >= CFG_W) begin : g_bad_aux
         $error("auxiliary fields exceed the word");
      end
   endgenerate

   wire wr_base = we && (cfg_sel_e'(sel) == CFG_BASE);
   wire wr_aux  = we && (cfg_sel_e'(sel) == CFG_AUX);

   // written-since-reset flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_seen_o <= 1'b0;
         aux_seen_o  <= 1'b0;
      end else begin
         if (wr_base) base_seen_o <= 1'b1;
         if (wr_aux)  aux_seen_o  <= 1'b1;
      end
   end

   // contents are undefined until written; the flags gate their use
   always_ff @(posedge clk) begin
      if (wr_base) begin
         base_o   <= wdata[CFG_W-1 -: BASE_W];
         wait_a_o <= wdata[WA_W-1:0];
         rdy_a_o  <= wdata[RDY_A_BIT];
      end
      if (wr_aux) begin
         wait_b_o <= wdata[WB_W-1:0];
         rdy_b_o  <= wdata[RDY_B_BIT];
         io_o     <= wdata[IO_BIT];
         amode_o  <= wdata[AMODE_BIT];
      end
   end
endmodule

// File: rtl/pcs_win_dec.sv
module pcs_win_dec
   import pcs_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int IO_W     = 16,
   parameter int WIN_BITS = 8,
   parameter int BASE_W   = 9
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_io,
   input  logic [BASE_W-1:0] base,
   input  logic              io_space,
   input  logic              amode,
   input  logic              en,
   output logic              hit_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam int BLK_BITS = WIN_BITS + SLOT_W;
   localparam int IOB_W    = IO_W - BLK_BITS;

   generate
      if (ADDR_W - BLK_BITS != BASE_W) begin : g_bad_base
         $error("base width does not match the address split");
      end
      if (IOB_W < 1 || IO_W > ADDR_W) begin : g_bad_io
         $error("I/O space does not fit the block layout");
      end
   endgenerate

   logic [SLOTS-1:0] slot_ok;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         if (i == HOLE_SLOT || i == SLOTS - 1) begin : g_none
            assign slot_ok[i] = 1'b0;
         end else if (i > HOLE_SLOT) begin : g_pin
            assign slot_ok[i] = ~amode;
         end else begin : g_low
            assign slot_ok[i] = 1'b1;
         end
      end
   endgenerate

   wire mem_match = (addr[ADDR_W-1 -: BASE_W] == base);
   wire io_match  = (addr[IO_W-1 -: IOB_W] == base[IOB_W-1:0]);
   wire space_ok  = io_space ? (is_io && io_match) : (!is_io && mem_match);

   assign slot_o = addr[BLK_BITS-1 -: SLOT_W];
   assign hit_o  = en && space_ok && slot_ok[slot_o];
endmodule

// File: rtl/pcs_wait_ctrl.sv
module pcs_wait_ctrl #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] load,
   input  logic             ext_rdy,
   input  logic             ready_in,
   output logic             busy_o,
   output logic             wait_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wait counter needs at least one bit");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             ext_q;

   wire [CNT_W-1:0] cur_cnt = launch ? load : cnt_q;
   wire             cur_ext = launch ? ext_rdy : ext_q;
   wire             active  = launch || busy_o;

   assign wait_o = active && ((cur_cnt != '0) || (cur_ext && !ready_in));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         ext_q  <= 1'b0;
      end else if (active) begin
         ext_q <= cur_ext;
         if (wait_o) begin
            busy_o <= 1'b1;
            cnt_q  <= (cur_cnt != '0) ? cur_cnt - 1'b1 : '0;
         end else begin
            busy_o <= 1'b0;
         end
      end
   end

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

   // R7
   rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q == '0 && wait_o) |-> (ext_q && !ready_in));
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
   import pcs_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int IO_W     = 16,
   parameter int WIN_BITS = 8,
   parameter int CFG_W    = 16,
   parameter int WA_W     = 4,
   parameter int WB_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_is_io,
   input  logic              bus_ready,
   output logic [NSEL-1:0]   sel_n,
   output logic              bus_wait
);
   localparam int BASE_W = ADDR_W - WIN_BITS - SLOT_W;
   localparam int CNT_W  = WA_W;

   generate
      if (WB_W > WA_W) begin : g_bad_wait
         $error("group-B wait field wider than the counter");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address pins need bits 1 and 2");
      end
   endgenerate

   logic [BASE_W-1:0] base;
   logic [WA_W-1:0]   wait_a;
   logic [WB_W-1:0]   wait_b;
   logic              rdy_a, rdy_b, io_space, amode;
   logic              base_seen, aux_seen;
   logic              hit, busy;
   logic [SLOT_W-1:0] dec_slot, slot_q;

   pcs_cfg_regs #(
      .CFG_W(CFG_W), .BASE_W(BASE_W), .WA_W(WA_W), .WB_W(WB_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .base_o(base), .wait_a_o(wait_a), .rdy_a_o(rdy_a),
      .wait_b_o(wait_b), .rdy_b_o(rdy_b), .io_o(io_space), .amode_o(amode),
      .base_seen_o(base_seen), .aux_seen_o(aux_seen)
   );

   wire both_seen = base_seen && aux_seen;
   wire pin_mode  = aux_seen && amode;

   pcs_win_dec #(
      .ADDR_W(ADDR_W), .IO_W(IO_W), .WIN_BITS(WIN_BITS), .BASE_W(BASE_W)
   ) u_dec (
      .addr(bus_addr), .is_io(bus_is_io), .base(base), .io_space(io_space),
      .amode(amode), .en(both_seen), .hit_o(hit), .slot_o(dec_slot)
   );

   wire             launch = cyc_start && !busy && hit;
   wire             grp_b  = (dec_slot > SLOT_W'(HOLE_SLOT));
   wire [CNT_W-1:0] load   = grp_b ? CNT_W'(wait_b) : CNT_W'(wait_a);
   wire             ext    = grp_b ? rdy_b : rdy_a;

   pcs_wait_ctrl #(.CNT_W(CNT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .launch(launch), .load(load),
      .ext_rdy(ext), .ready_in(bus_ready), .busy_o(busy), .wait_o(bus_wait)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q <= '0;
      else if (launch) slot_q <= dec_slot;
   end

   wire              cyc_on   = launch || busy;
   wire [SLOT_W-1:0] cur_slot = busy ? slot_q : dec_slot;

   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_out
         if (i == HOLE_SLOT) begin : g_hole
            assign sel_n[i] = 1'b1;
         end else if (i > HOLE_SLOT) begin : g_dual
            assign sel_n[i] = pin_mode ? bus_addr[i-HOLE_SLOT]
                                       : ~(cyc_on && cur_slot == SLOT_W'(i));
         end else begin : g_sel
            assign sel_n[i] = ~(cyc_on && cur_slot == SLOT_W'(i));
         end
      end
   endgenerate

   // selects seen as chip selects (address pins masked out)
   wire [NSEL-1:0] sel_low = ~sel_n & {{(NSEL-HOLE_SLOT-1){~pin_mode}}, {(HOLE_SLOT+1){1'b1}}};

   // R10
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_low));

   // R4
   no_early_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !both_seen |-> (&sel_n[HOLE_SLOT-1:0]));

   // R3
   wait_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> (sel_low != '0));
endmodule

// File: tb/pcs_decoder_test.sv
module pcs_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        cyc_start = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_is_io = 1'b0;
   logic        bus_ready = 1'b0;
   logic [6:0]  sel_n;
   logic        bus_wait;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // model of the configuration
   logic [8:0] m_ba;
   logic [3:0] m_w0;
   logic [1:0] m_w1;
   bit m_r0, m_r1, m_io, m_am, m_wr0, m_wr1;

   always #2 clk = ~clk;

   pcs_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .bus_addr(bus_addr),
      .bus_is_io(bus_is_io), .bus_ready(bus_ready), .sel_n(sel_n),
      .bus_wait(bus_wait)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; cyc_start = 0; cfg_we = 0; bus_ready = 0;
      m_wr0 = 0; m_wr1 = 0; m_am = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wr(input bit s, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      if (!s) begin
         m_ba = d[15:7]; m_r0 = d[4]; m_w0 = d[3:0]; m_wr0 = 1;
      end else begin
         m_w1 = d[1:0]; m_r1 = d[2]; m_io = d[3]; m_am = d[4]; m_wr1 = 1;
      end
   endtask

   function automatic logic [15:0] mk0(input logic [8:0] ba, input bit b6, input bit r, input logic [3:0] w);
      return {ba, b6, 1'b0, r, w};
   endfunction

   function automatic logic [15:0] mk1(input bit am, input bit io, input bit r, input logic [1:0] w);
      return {11'b0, am, io, r, w};
   endfunction

   function automatic bit exp_hit(input logic [19:0] a, input bit io);
      int k = int'(a[10:8]);
      bit sp = m_io ? (io && a[15:11] == m_ba[4:0]) : (!io && a[19:11] == m_ba);
      return m_wr0 && m_wr1 && sp && (k <= 3 || ((k == 5 || k == 6) && !m_am));
   endfunction

   function automatic logic [6:0] exp_sel(input logic [19:0] a, input bit h);
      logic [6:0] o = 7'h7F;
      if (h) o[a[10:8]] = 1'b0;
      if (m_wr1 && m_am) begin
         o[5] = a[1];
         o[6] = a[2];
      end
      return o;
   endfunction

   // one bus cycle; rd = extra clocks of ready low after the count
   task automatic run_cycle(input logic [19:0] a, input bit io, input int rd, input string tag);
      bit h = exp_hit(a, io);
      bit grp_b = (a[10:8] > 3'd4);
      int w = h ? (grp_b ? int'(m_w1) : int'(m_w0)) : 0;
      bit ext = h && (grp_b ? m_r1 : m_r0);
      int rde = ext ? rd : 0;
      logic [6:0] es = exp_sel(a, h);
      int n = 0;
      @(negedge clk);
      bus_addr = a; bus_is_io = io; cyc_start = 1;
      bus_ready = ext ? (n >= w + rd) : 1'b0;
      #1;
      while (1) begin
         chk(sel_n == es, {tag, " select"}, int'(sel_n), int'(es));
         if (!bus_wait || n >= 64) break;
         n++;
         @(negedge clk);
         cyc_start = 0;
         bus_ready = ext ? (n >= w + rd) : 1'b0;
         #1;
      end
      chk(n == w + rde, {tag, " wait clocks"}, n, w + rde);
      @(negedge clk);
      cyc_start = 0;
      #1;
      chk(sel_n == exp_sel(a, 1'b0), {tag, " idle select"}, int'(sel_n), int'(exp_sel(a, 1'b0)));
      chk(bus_wait == 1'b0, {tag, " idle wait"}, int'(bus_wait), 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk); #1;
      // R1 reset state
      chk(sel_n == 7'h7F, "R1 reset selects", int'(sel_n), 'h7F);
      chk(bus_wait == 1'b0, "R1 reset wait", int'(bus_wait), 0);

      // R4 base word alone
      wr(0, mk0(9'h0A5, 0, 0, 4'd2));
      run_cycle({9'h0A5, 3'd1, 8'h10}, 0, 0, "R4 base only");
      // R4 auxiliary word alone; R9 pins follow address without base word
      do_reset();
      wr(1, mk1(0, 0, 0, 2'd1));
      run_cycle({9'h0A5, 3'd5, 8'h02}, 0, 0, "R4 aux only");
      wr(1, mk1(1, 0, 0, 2'd1));
      for (int p = 0; p < 4; p++)
         run_cycle({9'h0A5, 3'd2, 5'd0, p[1:0], 1'b0}, 0, 0, "R9 aux-only pins");

      // R2 R3 R5 R6 R10 window sweep over several bases
      do_reset();
      wr(1, mk1(0, 0, 0, 2'd2));
      foreach (m_ba[i]) ;
      for (int b = 0; b < 3; b++) begin
         logic [8:0] ba = (b == 0) ? 9'h0A5 : (b == 1) ? 9'h000 : 9'h1FF;
         wr(0, mk0(ba, 0, 0, 4'd3));
         for (int k = 0; k < 8; k++)
            for (int l = 0; l < 3; l++) begin
               logic [7:0] lo = (l == 0) ? 8'h00 : (l == 1) ? 8'hFF : 8'h5A;
               run_cycle({ba, k[2:0], lo}, 0, 0, "R2 R3 R10 window");
            end
         // R3 outside the block
         run_cycle({ba + 9'd1, 3'd0, 8'h00}, 0, 0, "R3 above block");
         run_cycle({ba - 9'd1, 3'd3, 8'hFF}, 0, 0, "R3 below block");
      end

      // R5 every group-A wait value
      for (int w = 0; w < 16; w++) begin
         wr(0, mk0(9'h0A5, 0, 0, w[3:0]));
         run_cycle({9'h0A5, 3'd2, 8'h44}, 0, 0, "R5 wait sweep");
      end
      // R6 every group-B wait value
      for (int w = 0; w < 4; w++) begin
         wr(1, mk1(0, 0, 0, w[1:0]));
         run_cycle({9'h0A5, 3'd6, 8'h01}, 0, 0, "R6 wait sweep");
         run_cycle({9'h0A5, 3'd5, 8'hF0}, 0, 0, "R6 wait sweep");
      end

      // R7 ready mode, both groups
      for (int w = 0; w < 3; w += 2)
         for (int rd = 0; rd < 4; rd++) begin
            wr(0, mk0(9'h0A5, 0, 1, w[3:0]));
            run_cycle({9'h0A5, 3'd0, 8'h08}, 0, rd, "R7 ready group A");
         end
      wr(1, mk1(0, 0, 1, 2'd1));
      run_cycle({9'h0A5, 3'd6, 8'h08}, 0, 2, "R7 ready group B");
      // R7 ready ignored with bit clear (bench holds bus_ready low)
      wr(0, mk0(9'h0A5, 0, 0, 4'd1));
      run_cycle({9'h0A5, 3'd3, 8'h08}, 0, 3, "R7 ready ignored");

      // R2 base-word bit 6 has no effect
      wr(0, mk0(9'h0A5, 1, 0, 4'd1));
      run_cycle({9'h0A5, 3'd1, 8'h33}, 0, 0, "R2 bit6 ignored");
      run_cycle({9'h0A4, 3'd7, 8'h33}, 0, 0, "R2 bit6 ignored");

      // R8 I/O space
      wr(1, mk1(0, 1, 0, 2'd1));
      run_cycle({4'hF, 5'h05, 3'd1, 8'h20}, 1, 0, "R8 io hit");
      run_cycle({4'h0, 5'h05, 3'd6, 8'h20}, 1, 0, "R8 io hit");
      run_cycle({4'h0, 5'h05, 3'd1, 8'h20}, 0, 0, "R8 mem cycle in io space");
      run_cycle({4'h0, 5'h06, 3'd1, 8'h20}, 1, 0, "R8 io miss");
      wr(1, mk1(0, 0, 0, 2'd1));
      run_cycle({9'h0A5, 3'd1, 8'h20}, 1, 0, "R8 io cycle in mem space");

      // R9 address-pin mode with both words written
      wr(1, mk1(1, 0, 0, 2'd1));
      for (int p = 0; p < 4; p++) begin
         run_cycle({9'h0A5, 3'd5, 5'd3, p[1:0], 1'b1}, 0, 0, "R9 pins window 5");
         run_cycle({9'h0A5, 3'd6, 5'd0, p[1:0], 1'b0}, 0, 0, "R9 pins window 6");
         run_cycle({9'h0A5, 3'd0, 5'd1, p[1:0], 1'b0}, 0, 0, "R9 pins with select 0");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule